// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a parallel NOR flash bus. The host hands it one high-level request at a time on a valid/ready handshake: program a location, erase a sector, erase the whole chip, start an ID read, reset, enter or leave the shortened bypass programming mode, pause an erase, or continue it. The block turns the request into the unlock and command writes that the flash expects. For each write it drives an address, a data word, an active-low chip select and an active-low write enable.

The unlock and command addresses depend on the addressing mode, chosen by `cfg_byte_mode`. In word mode the first unlock/command address (U1) is 555h and the second (U2) is 2AAh. In byte mode U1 is AAAh and U2 is 555h. The block tracks whether bypass mode is on and whether an erase is running or paused. It refuses requests that are not legal in the current state. A refused request is consumed, produces no bus activity and raises a one-cycle `req_rej` pulse.

Back-pressure is simple. `req_ready` is high only while the sequencer is idle. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. The opcode, address, data, `cfg_byte_mode` and `cfg_we_clks` are all captured on that edge. `req_ready` then stays low until the last write of the sequence has finished its idle gap. Polling for completion is left to the host. The host reports the end of a running erase with the `erase_done` pulse.

Top module: `flash_cmd_seq`

## Requirements
- R1: Opcode 0 (program), with bypass off, issues exactly four writes: (U1,AAh), (U2,55h), (U1,A0h), then (req_addr,req_data). Word mode uses U1=555h and U2=2AAh.
- R2: When `cfg_byte_mode`=1 at acceptance, every unlock and command step uses U1=AAAh and U2=555h instead of the word-mode values.
- R3: Opcode 1 (sector erase) issues six writes: AAh, 55h, 80h, AAh and 55h to U1, U2, U1, U1, U2, then 30h to req_addr. Opcode 2 (chip erase) issues the same first five writes and ends with 10h written to U1. Command codes are zero-extended to the data width.
- R4: Opcode 5 (bypass enter) issues (U1,AAh), (U2,55h), (U1,20h) and turns bypass on. While bypass is on, opcode 0 issues only (0,A0h) then (req_addr,req_data).
- R5: Opcode 6 (bypass exit) issues (0,90h), (0,00h) and turns bypass off, after which programs use four writes again. Bypass entry is refused while an erase is pending or paused. While bypass is on, every opcode other than 0 and 6 is refused. Opcode 6 is refused while bypass is off.
- R6: An accepted opcode 1 or 2 makes an erase pending. Opcode 7 (suspend) issues (0,B0h) and is accepted only while a sector erase is pending; it makes the erase paused. Opcode 8 (resume) issues (0,30h) and is accepted only while paused; it returns the state to sector erase pending. While an erase is pending, only opcodes 7 (sector only) and 4 are accepted. While paused, only opcodes 0, 3, 4 and 8 are accepted.
- R7: Opcode 4 (reset) issues a single (0,F0h) and clears any erase state. An `erase_done` pulse clears a pending, unpaused erase.
- R8: Opcode 3 (ID read) issues (U1,AAh), (U2,55h), (U1,90h).
- R9: A refused request, and any opcode 9 to 15, produces no bus cycle. `req_rej` is high for exactly the cycle after the accepting edge, and `req_ready` stays high.
- R10: Each write starts with chip select low and write enable high for one clock. Write enable is then low for max(cfg_we_clks,1) clocks. Write enable then rises with chip select still low for one clock. Chip select is then high for at least one clock before the next write.
- R11: Address and data do not change while chip select stays low.
- R12: After an accepted request of N writes, `req_ready` is low for exactly N*(max(cfg_we_clks,1)+3) cycles.
- R13: After reset: chip select and write enable are high, `req_ready` is high, `req_rej` is low, bypass is off and no erase is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_byte_mode | input | 1 | 1 selects byte addressing for unlock/command steps |
| cfg_we_clks | input | PW | write-enable low time in clocks (0 treated as 1) |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | sequencer idle, request will be taken |
| req_op | input | 4 | request opcode |
| req_addr | input | AW | program or sector address |
| req_data | input | DW | program data |
| req_rej | output | 1 | one-cycle pulse: last taken request was refused |
| erase_done | input | 1 | pulse: running erase has finished |
| fl_addr | output | AW | flash address |
| fl_data | output | DW | flash write data |
| fl_cs_n | output | 1 | flash chip select, active low |
| fl_we_n | output | 1 | flash write enable, active low |

## Verification
The bench goes after the state-dependent corners:
- Suspend during a chip erase, and resume while not paused, must be refused. A design that accepted them would emit stray B0h or 30h writes.
- In bypass mode, any refusal gap would let a sector erase slip through as a two-write fragment.
- A program right after bypass exit must use all four writes again. A design that kept the bypass flag would emit a truncated program.
- Pulse widths of 0 and of more than one clock are timed edge by edge. Setting the word-mode and byte-mode unlock addresses on consecutive requests catches an addressing mode that was latched or decoded on the wrong edge.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam logic [3:0] OP_PROG   = 4'd0;
  localparam logic [3:0] OP_SERASE = 4'd1;
  localparam logic [3:0] OP_CERASE = 4'd2;
  localparam logic [3:0] OP_IDREAD = 4'd3;
  localparam logic [3:0] OP_RESET  = 4'd4;
  localparam logic [3:0] OP_BYP_ON = 4'd5;
  localparam logic [3:0] OP_BYP_OFF= 4'd6;
  localparam logic [3:0] OP_SUSP   = 4'd7;
  localparam logic [3:0] OP_RESUME = 4'd8;

  typedef enum logic [1:0] {AS_UNLK1, AS_UNLK2, AS_ZERO, AS_USER} asel_e;
  typedef enum logic [1:0] {ER_NONE, ER_SECTOR, ER_CHIP, ER_PAUSED} er_e;
  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD, PH_GAP} ph_e;

  typedef struct packed {
    asel_e      asel;
    logic       use_udata;
    logic [7:0] code;
    logic       last;
  } step_t;

  localparam int STEP_IW = 3;
endpackage

// File: rtl/fseq_step_table.sv
module fseq_step_table
  import fseq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic [3:0]         op,
  input  logic [STEP_IW-1:0] idx,
  input  logic               byp,
  input  logic               byte_mode,
  input  logic [AW-1:0]      user_addr,
  input  logic [DW-1:0]      user_data,
  output logic [AW-1:0]      step_addr,
  output logic [DW-1:0]      step_data,
  output logic               step_last
);
  localparam logic [AW-1:0] W_U1 = AW'(12'h555);
  localparam logic [AW-1:0] W_U2 = AW'(12'h2AA);
  localparam logic [AW-1:0] B_U1 = AW'(12'hAAA);
  localparam logic [AW-1:0] B_U2 = AW'(12'h555);

  function automatic step_t mk(asel_e a, logic u, logic [7:0] c, logic l);
    step_t s;
    s.asel = a; s.use_udata = u; s.code = c; s.last = l;
    return s;
  endfunction

  // two-write unlock prefix, shared by all long sequences
  function automatic step_t unlock(logic [STEP_IW-1:0] i);
    return (i == 3'd0 || i == 3'd3) ? mk(AS_UNLK1, 1'b0, 8'hAA, 1'b0)
                                    : mk(AS_UNLK2, 1'b0, 8'h55, 1'b0);
  endfunction

  step_t st;

  always_comb begin
    st = mk(AS_ZERO, 1'b0, 8'h00, 1'b1);
    case (op)
      OP_PROG:
        if (byp) st = (idx == 3'd0) ? mk(AS_ZERO, 1'b0, 8'hA0, 1'b0)
                                    : mk(AS_USER, 1'b1, 8'h00, 1'b1);
        else if (idx < 3'd2) st = unlock(idx);
        else if (idx == 3'd2) st = mk(AS_UNLK1, 1'b0, 8'hA0, 1'b0);
        else st = mk(AS_USER, 1'b1, 8'h00, 1'b1);
      OP_SERASE, OP_CERASE:
        if (idx == 3'd2) st = mk(AS_UNLK1, 1'b0, 8'h80, 1'b0);
        else if (idx < 3'd5) st = unlock(idx);
        else if (op == OP_SERASE) st = mk(AS_USER, 1'b0, 8'h30, 1'b1);
        else st = mk(AS_UNLK1, 1'b0, 8'h10, 1'b1);
      OP_IDREAD, OP_BYP_ON:
        if (idx < 3'd2) st = unlock(idx);
        else st = mk(AS_UNLK1, 1'b0, (op == OP_IDREAD) ? 8'h90 : 8'h20, 1'b1);
      OP_RESET:   st = mk(AS_ZERO, 1'b0, 8'hF0, 1'b1);
      OP_BYP_OFF: st = (idx == 3'd0) ? mk(AS_ZERO, 1'b0, 8'h90, 1'b0)
                                     : mk(AS_ZERO, 1'b0, 8'h00, 1'b1);
      OP_SUSP:    st = mk(AS_ZERO, 1'b0, 8'hB0, 1'b1);
      OP_RESUME:  st = mk(AS_ZERO, 1'b0, 8'h30, 1'b1);
      default:    st = mk(AS_ZERO, 1'b0, 8'h00, 1'b1);
    endcase
  end

  always_comb begin
    case (st.asel)
      AS_UNLK1: step_addr = byte_mode ? B_U1 : W_U1;
      AS_UNLK2: step_addr = byte_mode ? B_U2 : W_U2;
      AS_USER:  step_addr = user_addr;
      default:  step_addr = '0;
    endcase
    step_data = st.use_udata ? user_data : DW'(st.code);
    step_last = st.last;
  end
endmodule

// File: rtl/fseq_mode.sv
module fseq_mode
  import fseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op,
  input  logic       take,
  input  logic       erase_done,
  output logic       allow,
  output logic       byp
);
  er_e er;

  always_comb begin
    allow = 1'b0;
    if (byp) allow = (op == OP_PROG) || (op == OP_BYP_OFF);
    else begin
      case (er)
        ER_NONE:   allow = (op <= OP_BYP_ON);
        ER_SECTOR: allow = (op == OP_SUSP) || (op == OP_RESET);
        ER_CHIP:   allow = (op == OP_RESET);
        default:   allow = (op == OP_PROG) || (op == OP_IDREAD) ||
                           (op == OP_RESET) || (op == OP_RESUME);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      er  <= ER_NONE;
      byp <= 1'b0;
    end else if (take && allow) begin
      case (op)
        OP_SERASE:  er  <= ER_SECTOR;
        OP_CERASE:  er  <= ER_CHIP;
        OP_SUSP:    er  <= ER_PAUSED;
        OP_RESUME:  er  <= ER_SECTOR;
        OP_RESET:   er  <= ER_NONE;
        OP_BYP_ON:  byp <= 1'b1;
        OP_BYP_OFF: byp <= 1'b0;
        default: ;
      endcase
    end else if (erase_done && (er == ER_SECTOR || er == ER_CHIP)) begin
      er <= ER_NONE;
    end
  end

  // R5: bypass and erase activity never coexist
  a_r5_byp_no_erase: assert property (@(posedge clk) disable iff (!rst_n)
    byp |-> (er == ER_NONE));
  // R6: a paused erase can only come from a running sector erase
  a_r6_pause_from_sector: assert property (@(posedge clk) disable iff (!rst_n)
    (er == ER_PAUSED && $past(er) != ER_PAUSED) |-> $past(er) == ER_SECTOR);
endmodule

// File: rtl/fseq_strobe.sv
module fseq_strobe
  import fseq_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] pulse_len,
  output logic          cs_n,
  output logic          we_n,
  output logic          done
);
  ph_e           ph;
  logic [PW-1:0] cnt;
  logic [PW-1:0] eff_len;

  assign eff_len = (pulse_len == '0) ? PW'(1) : pulse_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE:  if (start) ph <= PH_SETUP;
        PH_SETUP: begin ph <= PH_LOW; cnt <= eff_len - PW'(1); end
        PH_LOW:   if (cnt == '0) ph <= PH_HOLD; else cnt <= cnt - PW'(1);
        PH_HOLD:  ph <= PH_GAP;
        default:  ph <= start ? PH_SETUP : PH_IDLE;
      endcase
    end
  end

  assign cs_n = (ph == PH_IDLE) || (ph == PH_GAP);
  assign we_n = (ph != PH_LOW);
  assign done = (ph == PH_GAP);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_byte_mode,
  input  logic [PW-1:0] cfg_we_clks,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_rej,
  input  logic          erase_done,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_data,
  output logic          fl_cs_n,
  output logic          fl_we_n
);
  logic               busy, take, allow, byp_now, st_done, st_last, st_start;
  logic [STEP_IW-1:0] idx;
  logic [3:0]         op_q;
  logic [AW-1:0]      addr_q;
  logic [DW-1:0]      data_q;
  logic               byte_q, byp_q;
  logic [PW-1:0]      plen_q;

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;
  assign st_start  = (take && allow) || (busy && st_done && !st_last);

  fseq_mode u_mode (
    .clk(clk), .rst_n(rst_n), .op(req_op), .take(take),
    .erase_done(erase_done), .allow(allow), .byp(byp_now)
  );

  fseq_step_table #(.AW(AW), .DW(DW)) u_table (
    .op(op_q), .idx(idx), .byp(byp_q), .byte_mode(byte_q),
    .user_addr(addr_q), .user_data(data_q),
    .step_addr(fl_addr), .step_data(fl_data), .step_last(st_last)
  );

  fseq_strobe #(.PW(PW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(st_start), .pulse_len(plen_q),
    .cs_n(fl_cs_n), .we_n(fl_we_n), .done(st_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      op_q    <= OP_RESET;
      addr_q  <= '0;
      data_q  <= '0;
      byte_q  <= 1'b0;
      byp_q   <= 1'b0;
      plen_q  <= PW'(1);
      req_rej <= 1'b0;
    end else begin
      req_rej <= take && !allow;
      if (take && allow) begin
        busy   <= 1'b1;
        idx    <= '0;
        op_q   <= req_op;
        addr_q <= req_addr;
        data_q <= req_data;
        byte_q <= cfg_byte_mode;
        byp_q  <= byp_now;
        plen_q <= cfg_we_clks;
      end else if (busy && st_done) begin
        if (st_last) busy <= 1'b0;
        else idx <= idx + STEP_IW'(1);
      end
    end
  end

  // checker state: clocks spent with write enable low
  logic [PW:0]   wl_cnt;
  logic [PW-1:0] eff_q;
  assign eff_q = (plen_q == '0) ? PW'(1) : plen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) wl_cnt <= '0;
    else wl_cnt <= fl_we_n ? '0 : wl_cnt + (PW+1)'(1);
  end

  // R10: write enable low exactly for the captured pulse length
  a_r10_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (wl_cnt == {1'b0, eff_q}));
  // R11: address and data held while chip select stays low
  a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_cs_n && $past(!fl_cs_n)) |-> ($stable(fl_addr) && $stable(fl_data)));
  // R12: no request can be taken while a bus cycle is open
  a_r12_ready_low_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_cs_n |-> !req_ready);
  // R9: a refused request starts no bus cycle
  a_r9_rej_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    req_rej |-> (fl_cs_n && req_ready));
endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int PW = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_byte_mode = 1'b0;
  logic [PW-1:0] cfg_we_clks = '0;
  logic req_valid = 1'b0, req_ready, req_rej, erase_done = 1'b0;
  logic [3:0] req_op = '0;
  logic [AW-1:0] req_addr = '0, fl_addr;
  logic [DW-1:0] req_data = '0, fl_data;
  logic fl_cs_n, fl_we_n;

  flash_cmd_seq #(.AW(AW), .DW(DW), .PW(PW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog act=%0d exp<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // bus monitor
  int wr_cnt = 0, tm_err = 0, wl = 0, cur_eff = 1;
  logic [AW-1:0] wr_a [8];
  logic [DW-1:0] wr_d [8];
  logic p_cs = 1'b1, p_we = 1'b1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_cs_n && !p_cs && (fl_addr != p_addr || fl_data != p_data)) tm_err++;
      if (!fl_we_n && fl_cs_n) tm_err++;
      if (!fl_we_n && p_we) begin
        if (p_cs) tm_err++;
        if (wr_cnt < 8) begin wr_a[wr_cnt] = fl_addr; wr_d[wr_cnt] = fl_data; end
        wr_cnt++;
        wl = 1;
      end else if (!fl_we_n) wl++;
      if (fl_we_n && !p_we) begin
        if (wl != cur_eff) tm_err++;
        if (fl_cs_n) tm_err++;
      end
      if (fl_cs_n && !p_cs && !p_we) tm_err++;
    end
    p_cs = fl_cs_n; p_we = fl_we_n; p_addr = fl_addr; p_data = fl_data;
  end

  // reference model of the mode state
  bit m_byp = 0;
  int m_er = 0; // 0 none, 1 sector, 2 chip, 3 paused
  int e_n;
  logic [AW-1:0] e_a [8];
  logic [DW-1:0] e_d [8];

  function automatic bit m_allow(logic [3:0] op);
    if (m_byp) return (op == 0) || (op == 6);
    case (m_er)
      0: return op <= 5;
      1: return (op == 7) || (op == 4);
      2: return op == 4;
      default: return (op == 0) || (op == 3) || (op == 4) || (op == 8);
    endcase
  endfunction

  function automatic void push(logic [AW-1:0] a, logic [DW-1:0] d);
    e_a[e_n] = a; e_d[e_n] = d; e_n++;
  endfunction

  function automatic void build(logic [3:0] op, logic [AW-1:0] a, logic [DW-1:0] d, bit bm);
    logic [AW-1:0] u1 = bm ? AW'('hAAA) : AW'('h555);
    logic [AW-1:0] u2 = bm ? AW'('h555) : AW'('h2AA);
    e_n = 0;
    case (op)
      0: if (m_byp) begin push(0, 'hA0); push(a, d); end
         else begin push(u1, 'hAA); push(u2, 'h55); push(u1, 'hA0); push(a, d); end
      1, 2: begin
        push(u1, 'hAA); push(u2, 'h55); push(u1, 'h80); push(u1, 'hAA); push(u2, 'h55);
        if (op == 1) push(a, 'h30); else push(u1, 'h10);
      end
      3: begin push(u1, 'hAA); push(u2, 'h55); push(u1, 'h90); end
      4: push(0, 'hF0);
      5: begin push(u1, 'hAA); push(u2, 'h55); push(u1, 'h20); end
      6: begin push(0, 'h90); push(0, 'h00); end
      7: push(0, 'hB0);
      8: push(0, 'h30);
      default: ;
    endcase
  endfunction

  function automatic void m_update(logic [3:0] op);
    case (op)
      1: m_er = 1;
      2: m_er = 2;
      4: m_er = 0;
      5: m_byp = 1;
      6: m_byp = 0;
      7: m_er = 3;
      8: m_er = 1;
      default: ;
    endcase
  endfunction

  task automatic do_req(logic [3:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                        bit bm, int plen, string tag);
    bit ok = m_allow(op);
    int eff = (plen == 0) ? 1 : plen;
    int busy = 0, exp_busy;
    bit same = 1;
    if (ok) build(op, a, d, bm); else e_n = 0;
    exp_busy = e_n * (eff + 3);
    @(negedge clk);
    wr_cnt = 0; tm_err = 0; cur_eff = eff;
    cfg_byte_mode = bm; cfg_we_clks = PW'(plen);
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_rej == !ok, ok ? tag : "R9", "req_rej", longint'(req_rej), longint'(!ok));
    while (!req_ready && busy < 1000) begin busy++; @(negedge clk); end
    chk(busy == exp_busy, "R12", "busy cycles", busy, exp_busy);
    chk(wr_cnt == e_n, ok ? tag : "R9", "write count", wr_cnt, e_n);
    for (int i = 0; i < e_n && i < wr_cnt; i++)
      if (wr_a[i] != e_a[i] || wr_d[i] != e_d[i]) begin
        if (same) chk(1'b0, tag, "write addr/data", {wr_a[i], wr_d[i]}, {e_a[i], e_d[i]});
        same = 0;
      end
    if (same && e_n > 0) chk(1'b1, tag, "writes", 0, 0);
    chk(tm_err == 0, "R10 R11", "timing violations", tm_err, 0);
    if (ok) m_update(op);
  endtask

  task automatic pulse_done();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    if (!m_byp && (m_er == 1 || m_er == 2)) m_er = 0;
  endtask

  function automatic string tag_of(logic [3:0] op);
    case (op)
      0: return m_byp ? "R4" : "R1";
      1, 2: return "R3";
      3: return "R8";
      4: return "R7";
      5: return "R4";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_0F1A));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(fl_cs_n === 1'b1, "R13", "cs_n", fl_cs_n, 1);
    chk(fl_we_n === 1'b1, "R13", "we_n", fl_we_n, 1);
    chk(req_ready === 1'b1, "R13", "ready", req_ready, 1);
    chk(req_rej === 1'b0, "R13", "rej", req_rej, 0);

    do_req(0, 'h12345, 'hBEEF, 0, 2, "R1");
    do_req(0, 'h00777, 'h1234, 1, 1, "R2");
    do_req(8, 0, 0, 0, 1, "R6");
    do_req(9, 0, 0, 0, 1, "R9");
    do_req(6, 0, 0, 0, 1, "R5");
    do_req(1, 'h3F000, 0, 0, 0, "R3");
    do_req(1, 'h3F000, 0, 0, 1, "R6");
    do_req(5, 0, 0, 0, 1, "R5");
    do_req(7, 0, 0, 0, 3, "R6");
    do_req(0, 'h00010, 'hA5A5, 1, 1, "R6");
    do_req(8, 0, 0, 0, 1, "R6");
    pulse_done();
    do_req(7, 0, 0, 0, 1, "R7");
    do_req(2, 0, 0, 1, 2, "R3");
    do_req(7, 0, 0, 0, 1, "R6");
    do_req(4, 'hFFFFF, 0, 0, 1, "R7");
    do_req(7, 0, 0, 0, 1, "R7");
    do_req(3, 0, 0, 0, 5, "R8");
    do_req(5, 0, 0, 1, 1, "R4");
    do_req(0, 'h0ABCD, 'h5A5A, 1, 1, "R4");
    do_req(1, 'h10000, 0, 0, 1, "R5");
    do_req(6, 0, 0, 0, 1, "R5");
    do_req(0, 'h0ABCD, 'h0F0F, 0, 1, "R5");

    for (int i = 0; i < 220; i++) begin
      logic [3:0] op = 4'($urandom % 10);
      if ($urandom % 8 == 0) pulse_done();
      do_req(op, AW'($urandom), DW'($urandom), bit'($urandom % 2),
             int'($urandom % 4), tag_of(op));
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule